// File: doc/BRIEF.md
# Multi-Digit BCD to Seven-Segment Decoder with Zero Blanking

This block turns a row of packed BCD digits into active-low segment drive for a common-anode display. A segment lights when its output is 0. Each digit has a segment decoder with its own blanking input, and one lamp-test input is shared by all digits. A ripple signal passes from the most significant digit down toward the least significant one. It blanks leading zeros, so a value such as 0042 shows as two blank places followed by "42".

The block is purely combinational and is built from a parameterised number of identical digit units. For each digit, the controls are honoured in a fixed order: the blanking input first, then lamp test, then ripple zero suppression, and ordinary decoding last. The least significant digit is never suppressed by the ripple, so a zero value still shows a single "0". Codes 10 to 15 are not valid BCD and leave the digit dark.

Top module: `bcd_display_decoder`

## Requirements
- R1: With its blanking input high, lamp test high and no suppression, a digit drives seg_n[7*i+6:7*i] = {g,f,e,d,c,b,a}, each bit active-low (0 = lit). The digits light these segments: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all, 9 abcdfg. Digit i takes its code from bcd_in[4*i+3:4*i], and digit 0 is the least significant.
- R2: When blank_n[i] is 0, all seven segment outputs of digit i are 1 (dark) and ripple_out_n[i] is 1, whatever the other inputs are.
- R3: When lamp_test_n is 0, every digit whose blank_n bit is 1 drives all seven segment outputs 0 (lit) and sets its ripple_out_n bit to 1.
- R4: When a digit's ripple input is 0, its code is 0, its blanking input is 1 and lamp test is 1, all of its segments are dark and its ripple_out_n bit is 0.
- R5: In every other case, ripple_out_n[i] is 1. The ripple input of the most significant digit (DIGITS-1) is ripple_in_n. Each lower digit i takes ripple_out_n[i+1] as its ripple input.
- R6: Codes 10 to 15 leave all seven segments of the digit dark when neither the blanking input nor lamp test is active.
- R7: Digit 0 behaves as if its ripple input were always 1. It shows 0 rather than going dark, and its ripple_out_n bit is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcd_in | input | 4*DIGITS | Packed BCD codes, digit 0 in the low nibble |
| blank_n | input | DIGITS | Per-digit blanking input, active low, overrides all else |
| lamp_test_n | input | 1 | Shared lamp test, active low, lights every segment |
| ripple_in_n | input | 1 | Ripple blanking input of the most significant digit, active low |
| seg_n | output | 7*DIGITS | Active-low segments {g,f,e,d,c,b,a} per digit |
| ripple_out_n | output | DIGITS | Per-digit ripple blanking output, active low |

## Verification
The checker re-evaluates the outputs on every input change and checks five things: the blanking override, the all-lit lamp test, that a low ripple output appears only on a dark zero digit whose upstream ripple is low, the dark invalid codes, and that digit 0 always shows a zero. The exact glyph for each BCD value and the way the ripple propagates are shown only by the bench. It compares each digit against a behavioural reference on every clock, first across all sixteen codes under each combination of blanking, lamp test and ripple input, then on chosen leading-zero values and random words.

// File: rtl/bcd_display_decoder.sv
module segdigit_unit (
  input  logic [3:0] code,
  input  logic       blank_n,
  input  logic       lamp_test_n,
  input  logic       ripple_in_n,
  output logic [6:0] seg_n,
  output logic       ripple_out_n
);
  logic [6:0] glyph;
  logic       zero_kill;

  always_comb begin
    case (code)
      4'd0:    glyph = 7'b0111111;
      4'd1:    glyph = 7'b0000110;
      4'd2:    glyph = 7'b1011011;
      4'd3:    glyph = 7'b1001111;
      4'd4:    glyph = 7'b1100110;
      4'd5:    glyph = 7'b1101101;
      4'd6:    glyph = 7'b1111101;
      4'd7:    glyph = 7'b0000111;
      4'd8:    glyph = 7'b1111111;
      4'd9:    glyph = 7'b1101111;
      default: glyph = 7'b0000000;
    endcase
  end

  assign zero_kill    = !ripple_in_n && (code == 4'd0);
  assign ripple_out_n = !(blank_n && lamp_test_n && zero_kill);

  always_comb begin
    if (!blank_n)          seg_n = '1;
    else if (!lamp_test_n) seg_n = '0;
    else if (zero_kill)    seg_n = '1;
    else                   seg_n = ~glyph;
  end
endmodule

module bcd_display_decoder #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] bcd_in,
  input  logic [DIGITS-1:0]   blank_n,
  input  logic                lamp_test_n,
  input  logic                ripple_in_n,
  output logic [7*DIGITS-1:0] seg_n,
  output logic [DIGITS-1:0]   ripple_out_n
);
  logic [DIGITS-1:0] rb_in;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    if (i == 0) begin : g_lsd
      assign rb_in[i] = 1'b1;
    end else if (i == DIGITS-1) begin : g_msd
      assign rb_in[i] = ripple_in_n;
    end else begin : g_mid
      assign rb_in[i] = ripple_out_n[i+1];
    end

    segdigit_unit u_digit (
      .code        (bcd_in[4*i +: 4]),
      .blank_n     (blank_n[i]),
      .lamp_test_n (lamp_test_n),
      .ripple_in_n (rb_in[i]),
      .seg_n       (seg_n[7*i +: 7]),
      .ripple_out_n(ripple_out_n[i])
    );
  end
endmodule

// File: rtl/bcd_display_decoder_chk.sv
module bcd_display_decoder_chk #(
  parameter int DIGITS = 4
) (
  input logic [4*DIGITS-1:0] bcd_in,
  input logic [DIGITS-1:0]   blank_n,
  input logic                lamp_test_n,
  input logic                ripple_in_n,
  input logic [7*DIGITS-1:0] seg_n,
  input logic [DIGITS-1:0]   ripple_out_n
);
  always_comb begin
    for (int i = 0; i < DIGITS; i++) begin
      if (!blank_n[i])
        assert_blank_override_R2: assert (seg_n[7*i +: 7] == 7'h7F && ripple_out_n[i]);
      if (blank_n[i] && !lamp_test_n)
        assert_lamp_all_lit_R3: assert (seg_n[7*i +: 7] == 7'h00 && ripple_out_n[i]);
      if (!ripple_out_n[i])
        assert_ripple_dark_zero_R4: assert (seg_n[7*i +: 7] == 7'h7F && bcd_in[4*i +: 4] == 4'd0);
      if (!ripple_out_n[i])
        assert_ripple_chain_R5: assert (i != 0 &&
          ((i == DIGITS-1) ? !ripple_in_n : !ripple_out_n[(i == DIGITS-1) ? i : i+1]));
      if (blank_n[i] && lamp_test_n && bcd_in[4*i +: 4] > 4'd9)
        assert_invalid_dark_R6: assert (seg_n[7*i +: 7] == 7'h7F);
    end
    if (blank_n[0] && lamp_test_n && bcd_in[3:0] == 4'd0)
      assert_lsd_zero_shown_R7: assert (seg_n[6:0] == 7'b1000000);
  end
endmodule

bind bcd_display_decoder bcd_display_decoder_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/bcd_display_decoder_tb.sv
module bcd_display_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIGITS = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4*DIGITS-1:0] bcd_in;
  logic [DIGITS-1:0]   blank_n;
  logic                lamp_test_n;
  logic                ripple_in_n;
  logic [7*DIGITS-1:0] seg_n;
  logic [DIGITS-1:0]   ripple_out_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bcd_display_decoder #(.DIGITS(DIGITS)) u_dut (.*);

  function automatic logic [6:0] lit_mask(string s);
    logic [6:0] m = '0;
    for (int k = 0; k < s.len(); k++) m[s[k] - "a"] = 1'b1;
    return m;
  endfunction

  function automatic string glyph_letters(int v);
    string t[10] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg",
                     "acdfg", "acdefg", "abc", "abcdefg", "abcdfg"};
    return (v < 10) ? t[v] : "";
  endfunction

  task automatic check_all();
    int rb = ripple_in_n;
    for (int d = DIGITS-1; d >= 0; d--) begin
      int code = int'(bcd_in[4*d +: 4]);
      int rin  = (d == 0) ? 1 : rb;
      logic [6:0] es;
      logic       er = 1'b1;
      string      tag;
      if (!blank_n[d])           begin es = 7'h7F; tag = "R2"; end
      else if (!lamp_test_n)     begin es = 7'h00; tag = "R3"; end
      else if (rin == 0 && code == 0) begin es = 7'h7F; er = 1'b0; tag = "R4"; end
      else begin
        es  = ~lit_mask(glyph_letters(code));
        tag = (code > 9) ? "R6" : (d == 0 && code == 0) ? "R7" : "R1";
      end
      rb = er;
      checks++;
      if (seg_n[7*d +: 7] !== es) begin
        fails++;
        $display("FAIL %s digit %0d seg_n actual %b expected %b", tag, d, seg_n[7*d +: 7], es);
      end
      checks++;
      if (ripple_out_n[d] !== er) begin
        fails++;
        $display("FAIL R5 digit %0d ripple_out_n actual %b expected %b", d, ripple_out_n[d], er);
      end
    end
  endtask

  task automatic apply(logic [4*DIGITS-1:0] b, logic [DIGITS-1:0] bl, logic lt, logic ri);
    @(posedge clk);
    #1;
    bcd_in = b; blank_n = bl; lamp_test_n = lt; ripple_in_n = ri;
    @(negedge clk);
    check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bcd_in = '0; blank_n = '1; lamp_test_n = 1'b1; ripple_in_n = 1'b1;
    // reset/idle state: all zeros shown with ripple high -> R1 and R7
    apply('0, '1, 1'b1, 1'b1);
    // exhaustive codes under blanking, lamp-test and ripple combinations (R1..R6)
    for (int c = 0; c < 16; c++)
      for (int bl = 0; bl < 2; bl++)
        for (int lt = 0; lt < 2; lt++)
          for (int ri = 0; ri < 2; ri++)
            apply({DIGITS{4'(c)}}, {DIGITS{1'(bl)}}, 1'(lt), 1'(ri));
    // leading-zero chains (R4, R5, R7)
    apply(16'h0042, '1, 1'b1, 1'b0);
    apply(16'h0000, '1, 1'b1, 1'b0);
    apply(16'h0405, '1, 1'b1, 1'b0);
    apply(16'h0007, '1, 1'b1, 1'b0);
    apply(16'h1000, '1, 1'b1, 1'b0);
    apply(16'h0000, '1, 1'b1, 1'b1);
    // blanking of the top digit breaks the ripple chain (R2, R5)
    apply(16'h0003, 4'b0111, 1'b1, 1'b0);
    // lamp test over suppressed zeros (R3)
    apply(16'h0000, '1, 1'b0, 1'b0);
    // random words
    for (int n = 0; n < 400; n++)
      apply(16'($urandom), 4'($urandom) | 4'($urandom), 1'($urandom_range(0, 7) != 0),
            1'($urandom));
    finish_run();
  end
endmodule